// File: doc/BRIEF.md
# DRAM Clock-Enable Power-Down Sequencer

This block sits on the controller side of a DDR2-class SDRAM interface. It puts the memory into clock-enable power-down when the scheduler goes idle, and it brings the memory back out. At entry it reads whether any bank still has an open row. If none does, it uses the precharge flavour. If one does, it uses the active flavour, and a mode bit then chooses fast or slow exit. That choice fixes how long the command path stays closed after CKE rises.

While the device is down, CKE is held low. The sequencer counts the low time both ways. A wake request is honoured only after the minimum low width has passed; an earlier request is remembered. The sequencer also forces an exit of its own before the residency ceiling, which is nine refresh intervals, and it raises a one-cycle refresh-due pulse so a refresh can be queued. On the way out it holds CKE high with NOP for at least the minimum pulse width. It reopens the command gate only once the exit latency of the chosen flavour has elapsed, counted from the rise of CKE.

Top module: `pdn_sequencer`

## Requirements
- R1: While reset is held and right after it, `cke` is 1, `cmd_en` is 1, `cmd_nop` is 0 and `refresh_wake` is 0.
- R2: When `cmd_en` is 1 and `sleep_req` is 1 with `sched_busy` 0 at a clock edge, `cke` is 0, `cmd_nop` is 1 and `cmd_en` is 0 in the following cycle. With `sched_busy` 1 the request is ignored and `cmd_en` stays 1.
- R3: The flavour is latched at entry. `bank_open`=0 selects precharge with exit latency T_XP. `bank_open`=1 with `fast_exit`=1 selects active fast exit with T_XARD. `bank_open`=1 with `fast_exit`=0 selects active slow exit with T_XARDS.
- R4: Once `cke` falls it stays 0 for at least T_CKE cycles, counting the entry cycle.
- R5: A `wake_req` pulse seen while `cke` is 0 but before T_CKE low cycles have passed is remembered. Exit then starts as soon as the low count reaches T_CKE.
- R6: Once `cke` rises it stays 1 for at least T_CKE cycles, with `cmd_nop` 1 and `cmd_en` 0 throughout.
- R7: `cmd_en` returns to 1 exactly max(T_CKE, L) cycles after `cke` rises, where L is the exit latency of the latched flavour.
- R8: `cke` is never low for more than 9*T_REFI-1 consecutive cycles. At that count an exit starts without any wake request.
- R9: `refresh_wake` is a single-cycle pulse in the first high cycle of an exit, and only when that exit was reached at the residency limit.
- R10: `wake_req` has no effect while `cke` is 1, and `sleep_req` has no effect while `cmd_en` is 0.
- R11: `cmd_en` is never 1 while `cke` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sleep_req | input | 1 | Idle request to enter power-down |
| wake_req | input | 1 | Request to leave power-down |
| bank_open | input | 1 | 1 when any bank holds an open row |
| fast_exit | input | 1 | Active power-down exit speed: 1 fast, 0 slow |
| sched_busy | input | 1 | 1 while the scheduler has a command in flight |
| cke | output | 1 | Clock enable to the memory |
| cmd_nop | output | 1 | Forces NOP/Deselect on the command bus |
| cmd_en | output | 1 | Command-valid gate to the scheduler |
| refresh_wake | output | 1 | Pulse: residency limit forced this exit |

## Verification
The forced exit at the residency ceiling is the hardest case to reach from the ports. No port shows the residency count, and any stray wake request ends the stay early. The stimulus therefore enters power-down, holds `wake_req` low for longer than nine refresh intervals, and checks that the refresh pulse arrives on the exact cycle the limit is reached. A second hard case is a wake that lands in the entry cycle itself. A directed step covers it, and a pseudo-random phase covers wakes that arrive during exit.

// File: rtl/pdn_pkg.sv
package pdn_pkg;

  typedef enum logic [2:0] {
    PD_ACTIVE,
    PD_ENTER,
    PD_DOWN,
    PD_EXIT_HOLD,
    PD_EXIT_WAIT
  } pd_state_e;

  typedef enum logic [1:0] {
    FLAV_PRE,
    FLAV_ACT_FAST,
    FLAV_ACT_SLOW
  } pd_flavour_e;

  // Flavour chosen from the bank state at the moment of entry
  function automatic pd_flavour_e pick_flavour(logic any_open, logic fast);
    if (!any_open) return FLAV_PRE;
    return fast ? FLAV_ACT_FAST : FLAV_ACT_SLOW;
  endfunction

  // Exit latency in cycles for a flavour
  function automatic int exit_latency(pd_flavour_e f, int xp, int xard, int xards);
    case (f)
      FLAV_PRE:      return xp;
      FLAV_ACT_FAST: return xard;
      default:       return xards;
    endcase
  endfunction

  // Longest allowed run of low CKE cycles: strictly under nine refresh intervals
  function automatic int residency_cap(int refi);
    return 9 * refi - 1;
  endfunction

  function automatic int max2(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pdn_timer.sv
module pdn_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         tick,
  output logic         done
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt_q <= '0;
    else if (load)                cnt_q <= load_val;
    else if (tick && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/pdn_sequencer.sv
module pdn_sequencer
  import pdn_pkg::*;
#(
  parameter int T_CKE   = 3,
  parameter int T_XP    = 4,
  parameter int T_XARD  = 2,
  parameter int T_XARDS = 6,
  parameter int T_REFI  = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_req,
  input  logic wake_req,
  input  logic bank_open,
  input  logic fast_exit,
  input  logic sched_busy,
  output logic cke,
  output logic cmd_nop,
  output logic cmd_en,
  output logic refresh_wake
);
  localparam int RES_LIM = residency_cap(T_REFI);
  localparam int MAXV    = max2(max2(RES_LIM, T_CKE), max2(T_XP, max2(T_XARD, T_XARDS)));
  localparam int CW      = $clog2(MAXV + 1);

  pd_state_e   state_q, state_d;
  pd_flavour_e flav_q;
  logic        wake_pend_q, refresh_q;

  // Named internal events
  logic entry_fire, exit_fire, in_low, in_high;
  logic low_ok, res_hit, hold_done, lat_done, wake_seen;
  logic [CW-1:0] lat_load;

  assign in_low     = (state_q == PD_ENTER) || (state_q == PD_DOWN);
  assign in_high    = (state_q == PD_EXIT_HOLD) || (state_q == PD_EXIT_WAIT);
  assign entry_fire = (state_q == PD_ACTIVE) && sleep_req && !sched_busy;
  assign wake_seen  = wake_req || wake_pend_q;
  assign exit_fire  = (state_q == PD_DOWN) && ((wake_seen && low_ok) || res_hit);
  assign lat_load   = CW'(exit_latency(flav_q, T_XP, T_XARD, T_XARDS) - 1);

  // Minimum low width
  pdn_timer #(.W(CW)) u_low_tmr (
    .clk(clk), .rst_n(rst_n), .load(entry_fire),
    .load_val(CW'(T_CKE - 1)), .tick(in_low), .done(low_ok)
  );

  // Residency ceiling
  pdn_timer #(.W(CW)) u_res_tmr (
    .clk(clk), .rst_n(rst_n), .load(entry_fire),
    .load_val(CW'(RES_LIM - 1)), .tick(in_low), .done(res_hit)
  );

  // Minimum high width after exit begins
  pdn_timer #(.W(CW)) u_hold_tmr (
    .clk(clk), .rst_n(rst_n), .load(exit_fire),
    .load_val(CW'(T_CKE - 1)), .tick(in_high), .done(hold_done)
  );

  // Flavour-dependent exit latency
  pdn_timer #(.W(CW)) u_lat_tmr (
    .clk(clk), .rst_n(rst_n), .load(exit_fire),
    .load_val(lat_load), .tick(in_high), .done(lat_done)
  );

  always_comb begin
    state_d = state_q;
    case (state_q)
      PD_ACTIVE:    if (entry_fire) state_d = PD_ENTER;
      PD_ENTER:     state_d = PD_DOWN;
      PD_DOWN:      if (exit_fire) state_d = PD_EXIT_HOLD;
      PD_EXIT_HOLD: if (hold_done) state_d = lat_done ? PD_ACTIVE : PD_EXIT_WAIT;
      PD_EXIT_WAIT: if (lat_done) state_d = PD_ACTIVE;
      default:      state_d = PD_ACTIVE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= PD_ACTIVE;
      flav_q      <= FLAV_PRE;
      wake_pend_q <= 1'b0;
      refresh_q   <= 1'b0;
    end else begin
      state_q   <= state_d;
      refresh_q <= exit_fire && res_hit;
      if (entry_fire) flav_q <= pick_flavour(bank_open, fast_exit);
      if (exit_fire || !in_low) wake_pend_q <= 1'b0;
      else if (wake_req)        wake_pend_q <= 1'b1;
    end
  end

  assign cke          = !in_low;
  assign cmd_en       = (state_q == PD_ACTIVE);
  assign cmd_nop      = (state_q == PD_ENTER) || in_high;
  assign refresh_wake = refresh_q;
endmodule

// File: rtl/pdn_seq_chk.sv
module pdn_seq_chk #(
  parameter int T_CKE   = 3,
  parameter int RES_LIM = 71
) (
  input logic clk,
  input logic rst_n,
  input logic cke,
  input logic cmd_en,
  input logic cmd_nop,
  input logic refresh_wake,
  input logic sched_busy,
  input logic res_hit,
  input logic exit_fire
);
  logic [15:0] low_run, high_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_run  <= '0;
      high_run <= 16'(T_CKE);
    end else begin
      low_run  <= cke ? '0 : ((low_run == 16'hFFFF) ? low_run : low_run + 1'b1);
      high_run <= !cke ? '0 : ((high_run == 16'hFFFF) ? high_run : high_run + 1'b1);
    end
  end

  // R11
  gate_needs_cke_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_en |-> cke);

  // R2
  entry_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cke) |-> (cmd_nop && !cmd_en));

  // R2
  busy_blocks_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_en && sched_busy) |=> cmd_en);

  // R4
  min_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke) |-> ($past(low_run) >= 16'(T_CKE - 1)));

  // R6
  min_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cke) |-> ($past(high_run) >= 16'(T_CKE - 1)));

  // R8
  residency_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |-> (low_run < 16'(RES_LIM)));

  // R9
  refresh_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_wake |-> ($past(res_hit) && $past(exit_fire) && cke && !cmd_en));

  // R9
  refresh_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_wake |=> !refresh_wake);
endmodule

bind pdn_sequencer pdn_seq_chk #(.T_CKE(T_CKE), .RES_LIM(RES_LIM)) u_chk (
  .clk(clk), .rst_n(rst_n), .cke(cke), .cmd_en(cmd_en), .cmd_nop(cmd_nop),
  .refresh_wake(refresh_wake), .sched_busy(sched_busy),
  .res_hit(res_hit), .exit_fire(exit_fire)
);

// File: tb/pdn_sequencer_bench.sv
`timescale 1ns/1ps
module pdn_sequencer_bench;
  localparam int T_CKE = 3, T_XP = 4, T_XARD = 2, T_XARDS = 6, T_REFI = 8;
  localparam int RES = 9 * T_REFI - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sleep_req = 0, wake_req = 0, bank_open = 0, fast_exit = 0, sched_busy = 0;
  logic cke, cmd_nop, cmd_en, refresh_wake;

  int checks = 0, errors = 0, cycles = 0, refresh_seen = 0;
  string tag = "R1";

  always #2.5 clk = ~clk;

  pdn_sequencer #(.T_CKE(T_CKE), .T_XP(T_XP), .T_XARD(T_XARD),
                  .T_XARDS(T_XARDS), .T_REFI(T_REFI)) u_pdn_sequencer (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .wake_req(wake_req),
    .bank_open(bank_open), .fast_exit(fast_exit), .sched_busy(sched_busy),
    .cke(cke), .cmd_nop(cmd_nop), .cmd_en(cmd_en), .refresh_wake(refresh_wake));

  // Behavioural reference: phase 0 gate open, 1 CKE low, 2 CKE high with NOP
  int m_phase = 0, m_low = 0, m_high = 0, m_lat = 0;
  bit m_pend = 0, m_forced = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase = 0; m_pend = 0; m_forced = 0;
    end else begin
      cycles++;
      if (m_phase == 0) begin
        if (sleep_req && !sched_busy) begin
          m_phase = 1; m_low = 1; m_pend = 0;
          m_lat = !bank_open ? T_XP : (fast_exit ? T_XARD : T_XARDS);  // R3
        end
      end else if (m_phase == 1) begin
        bit w;
        w = m_pend || wake_req;                                         // R5
        if ((w && m_low >= T_CKE) || m_low >= RES) begin                // R4 R8
          m_phase = 2; m_high = 1; m_forced = (m_low >= RES); m_pend = 0;
        end else begin
          m_pend = w; m_low++;
        end
      end else begin
        if (m_high >= ((m_lat > T_CKE) ? m_lat : T_CKE)) m_phase = 0;   // R6 R7
        else m_high++;
      end
    end
  end

  task automatic cmp(string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    cmp("cke", cke, m_phase != 1);
    cmp("cmd_en", cmd_en, m_phase == 0);
    cmp("cmd_nop", cmd_nop, (m_phase == 2) || (m_phase == 1 && m_low == 1));
    cmp("refresh_wake", refresh_wake, m_phase == 2 && m_high == 1 && m_forced);
    if (refresh_wake) refresh_seen++;
  end

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pd_cycle(bit bo, bit fe, int wake_at, int settle);
    bank_open = bo; fast_exit = fe;
    sleep_req = 1; wait_n(1); sleep_req = 0;
    wait_n(wake_at); wake_req = 1; wait_n(1); wake_req = 0;
    wait_n(settle);
  endtask

  initial begin
    wait_n(2);
    // R1: outputs during reset
    tag = "R1";
    cmp("cke", cke, 1'b1); cmp("cmd_en", cmd_en, 1'b1);
    cmp("cmd_nop", cmd_nop, 1'b0); cmp("refresh_wake", refresh_wake, 1'b0);
    rst_n = 1; wait_n(2);

    // R2 R10: busy scheduler blocks entry
    tag = "R2"; sched_busy = 1; sleep_req = 1; wait_n(4);
    cmp("cmd_en", cmd_en, 1'b1);
    sleep_req = 0; sched_busy = 0; wait_n(1);

    // R3 R7: each flavour
    tag = "R3_pre";  pd_cycle(0, 0, 5, 12);
    tag = "R3_fast"; pd_cycle(1, 1, 5, 12);
    tag = "R7_slow"; pd_cycle(1, 0, 5, 12);

    // R4 R5: wake in the entry cycle and just after
    tag = "R5"; pd_cycle(1, 1, 0, 12);
    tag = "R4"; pd_cycle(0, 0, 1, 12);

    // R8 R9: no wake, residency forces exit
    tag = "R8"; refresh_seen = 0;
    bank_open = 1; fast_exit = 0; sleep_req = 1; wait_n(1); sleep_req = 0;
    wait_n(RES + 15);
    tag = "R9"; checks++;
    if (refresh_seen != 1) begin
      errors++;
      $display("FAIL R9 refresh pulses actual=%0d expected=1", refresh_seen);
    end

    // R10: wake while awake, sleep held through power-down
    tag = "R10"; wake_req = 1; wait_n(3); wake_req = 0;
    cmp("cmd_en", cmd_en, 1'b1);
    sleep_req = 1; wait_n(8); wake_req = 1; wait_n(1); wake_req = 0; wait_n(6);
    sleep_req = 0; wait_n(12);

    // R6 R11: pseudo-random traffic
    tag = "R6_R11_rand";
    for (int i = 0; i < 4000; i++) begin
      sleep_req  = ($urandom_range(0, 7) == 0);
      wake_req   = ($urandom_range(0, 15) == 0);
      sched_busy = ($urandom_range(0, 3) == 0);
      bank_open  = $urandom_range(0, 1);
      fast_exit  = $urandom_range(0, 1);
      wait_n(1);
    end
    sleep_req = 0; wake_req = 0; wait_n(RES + 20);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog expired after %0d cycles expected completion", cycles);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule